// File: doc/BRIEF.md
# Received-Octet Statistics Counter with Split Read

This block keeps a 48-bit running total of payload octets taken from received frames. A frame's octets are added only when all of these hold: the frame ended, it was error-free, it was kept by the address filter and stored, and it was not a flow-control pause frame. The total never wraps. If an addition would go past the largest value, the total stays at all ones.

A 32-bit host reads the total through two registers. Reading the low word returns bits 31:0 and clears the total. The same read latches bits 47:32 into a holding register. A later read of the high word returns the latched half, so the two words always describe the same instant.

For test, a host-controlled enable lets the host load either half directly. A one-cycle increment pulse adds one to the total.

Top module: `rx_octet_stat`

## Requirements
- R1: After reset, the low word (byte offset 0x150) and the high word (byte offset 0x154) both read as zero.
- R2: When `frm_done` is high together with `frm_good` and `frm_stored`, and `frm_pause` is low, `frm_len` is added to the total. The new total is visible from the next cycle.
- R3: A frame that is missing any of `frm_done`, `frm_good` or `frm_stored`, or that has `frm_pause` high, leaves the total unchanged.
- R4: If an addition would exceed 2^48-1, the total becomes all ones in that same cycle. Once at all ones, it stays there until it is read or written.
- R5: A read (`rd_en`) at offset 0x150 returns total bits 31:0 on `rdata` one cycle later. The read clears the total and latches total bits 47:32 into the holding register. Later additions do not change the latched half.
- R6: A read at offset 0x154 returns the latched half in `rdata[15:0]` and zero in `rdata[31:16]`. This read leaves the total unchanged.
- R7: An addition that arrives in the same cycle as a low-word read is kept. The total after that read equals the addition.
- R8: A write (`wr_en`) with `tst_wr_en` high loads total bits 31:0 from `wdata` at offset 0x150, or total bits 47:32 from `wdata[15:0]` at offset 0x154. With `tst_wr_en` low, the write has no effect.
- R9: A one-cycle `tst_inc` pulse adds one to the total. In the same cycle it adds on top of any qualifying frame length.
- R10: When `rd_en` and `wr_en` are both high, the read takes effect and the write is dropped. A test write in the same cycle as an addition overrides the addition.
- R11: A read at any other offset returns zero and leaves the total unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_done | input | 1 | One-cycle strobe at the end of a received frame |
| frm_len | input | LEN_W (14) | Octet count of the frame |
| frm_good | input | 1 | Frame was received without errors |
| frm_stored | input | 1 | Frame passed the filter and was stored |
| frm_pause | input | 1 | Frame is a pause frame |
| tst_inc | input | 1 | Test pulse: add one to the total |
| tst_wr_en | input | 1 | Test control: allow direct writes |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W (9) | Register byte offset |
| wdata | input | BUS_W (32) | Write data |
| rdata | output | BUS_W (32) | Read data, valid the cycle after `rd_en` |

## Verification
The bench builds the block with its default parameters: a 48-bit total, a 32-bit bus and 14-bit frame lengths.

Because the test write can load the total anywhere, the region just below 2^48-1 is reachable in a few cycles. The bench sweeps 41 starting points below the maximum and applies a fixed frame length at each one. This covers both sides of the clamp.

The bench also walks all sixteen combinations of the four frame flags at the shortest, typical, maximum-Ethernet and largest 14-bit lengths. It checks each same-cycle collision: read with addition, read with write, and write with addition.

// File: rtl/rx_octet_stat.sv
`timescale 1ns/1ps
module rx_octet_stat #(
  parameter int CNT_W  = 48,
  parameter int BUS_W  = 32,
  parameter int LEN_W  = 14,
  parameter int ADDR_W = 9,
  parameter logic [ADDR_W-1:0] LO_OFS = 9'h150,
  parameter logic [ADDR_W-1:0] HI_OFS = 9'h154
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_done,
  input  logic [LEN_W-1:0]  frm_len,
  input  logic              frm_good,
  input  logic              frm_stored,
  input  logic              frm_pause,
  input  logic              tst_inc,
  input  logic              tst_wr_en,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata
);
  localparam int HI_W = CNT_W - BUS_W;
  localparam logic [CNT_W-1:0] MAX = '1;

  logic [CNT_W-1:0] cnt;
  logic [HI_W-1:0]  hi_cap;
  logic [CNT_W-1:0] add_amt, base, nxt;
  logic [CNT_W:0]   sum;

  wire take  = frm_done & frm_good & frm_stored & ~frm_pause;
  wire rd_lo = rd_en & (addr == LO_OFS);
  wire rd_hi = rd_en & (addr == HI_OFS);
  wire wr_ok = wr_en & tst_wr_en & ~rd_en;
  wire wr_lo = wr_ok & (addr == LO_OFS);
  wire wr_hi = wr_ok & (addr == HI_OFS);

  assign add_amt = (take ? CNT_W'(frm_len) : '0) + CNT_W'(tst_inc);
  assign base    = rd_lo ? '0 : cnt;
  assign sum     = {1'b0, base} + {1'b0, add_amt};
  assign nxt     = sum[CNT_W] ? MAX : sum[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      hi_cap <= '0;
      rdata  <= '0;
    end else begin
      if (wr_lo)      cnt[BUS_W-1:0]     <= wdata;
      else if (wr_hi) cnt[CNT_W-1:BUS_W] <= wdata[HI_W-1:0];
      else            cnt                <= nxt;
      if (rd_lo) hi_cap <= cnt[CNT_W-1:BUS_W];
      if (rd_lo)      rdata <= cnt[BUS_W-1:0];
      else if (rd_hi) rdata <= BUS_W'(hi_cap);
      else            rdata <= '0;
    end
  end

  AST_PAUSE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_done && frm_pause && !tst_inc && !rd_en && !wr_en) |=> $stable(cnt)); // R3
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_lo && !wr_ok) |=> (cnt >= $past(cnt))); // R4
  AST_SAT_STICK: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == MAX && !rd_lo && !wr_ok) |=> (cnt == MAX)); // R4
  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo && !frm_done && !tst_inc) |=> (cnt == '0)); // R5
  AST_HI_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo |=> (hi_cap == $past(cnt[CNT_W-1:BUS_W]))); // R5
  AST_HI_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi |=> (rdata[BUS_W-1:HI_W] == '0)); // R6
  AST_NO_TEST_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !tst_wr_en && !rd_en && !frm_done && !tst_inc) |=> $stable(cnt)); // R8
endmodule

// File: tb/sim_rx_octet_stat.sv
`timescale 1ns/1ps
module sim_rx_octet_stat;
  localparam logic [8:0] LO = 9'h150, HI = 9'h154;
  localparam logic [47:0] MAX = '1;
  logic clk = 0, rst_n = 0;
  logic fd = 0, fg = 0, fs = 0, fp = 0, ti = 0, rd = 0, wr = 0, twe = 0;
  logic [13:0] len = '0;
  logic [8:0]  ad = '0;
  logic [31:0] wd = '0;
  wire  [31:0] rdata;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rx_octet_stat u0 (.clk(clk), .rst_n(rst_n), .frm_done(fd), .frm_len(len),
    .frm_good(fg), .frm_stored(fs), .frm_pause(fp), .tst_inc(ti), .tst_wr_en(twe),
    .rd_en(rd), .wr_en(wr), .addr(ad), .wdata(wd), .rdata(rdata));

  task automatic step(input bit f_d, f_g, f_s, f_p, input logic [13:0] l,
                      input bit t_i, r, w, te, input logic [8:0] a,
                      input logic [31:0] d, output logic [31:0] rv);
    @(negedge clk);
    fd = f_d; fg = f_g; fs = f_s; fp = f_p; len = l; ti = t_i;
    rd = r; wr = w; twe = te; ad = a; wd = d;
    @(negedge clk);
    fd = 0; fg = 0; fs = 0; fp = 0; len = '0; ti = 0; rd = 0; wr = 0; twe = 0; ad = '0; wd = '0;
    rv = rdata;
  endtask

  task automatic frame(input logic [13:0] l);
    logic [31:0] v;
    step(1, 1, 1, 0, l, 0, 0, 0, 0, '0, '0, v);
  endtask
  task automatic rdreg(input logic [8:0] a, output logic [31:0] v);
    step(0, 0, 0, 0, '0, 0, 1, 0, 0, a, '0, v);
  endtask
  task automatic wrreg(input logic [8:0] a, input logic [31:0] d, input bit te);
    logic [31:0] v;
    step(0, 0, 0, 0, '0, 0, 0, 1, te, a, d, v);
  endtask
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask
  task automatic chk48(input string tag, input logic [47:0] exp);
    logic [31:0] v;
    rdreg(LO, v); chk(tag, v, exp[31:0]);
    rdreg(HI, v); chk(tag, v, {16'h0, exp[47:32]});
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [47:0] e;
    logic [13:0] lens [4];
    lens[0] = 14'd1; lens[1] = 14'd64; lens[2] = 14'd1518; lens[3] = 14'h3FFF;
    repeat (3) @(negedge clk);
    rst_n = 1;

    chk48("R1 reset", 48'h0);

    for (int k = 0; k < 4; k++)
      for (int f = 0; f < 16; f++) begin
        step(f[0], f[1], f[2], f[3], lens[k], 0, 0, 0, 0, '0, '0, v);
        if (f == 7) chk48("R2 qualifying frame", {34'h0, lens[k]});
        else        chk48("R3 unqualified frame", 48'h0);
      end

    e = 0;
    for (int i = 0; i < 50; i++) begin
      frame(14'(i * 37 + 1));
      e += 48'(i * 37 + 1);
    end
    chk48("R2 accumulate", e);

    wrreg(HI, 32'hFFFF_ABCD, 1);
    wrreg(LO, 32'h1234_5678, 1);
    chk48("R8 test write / R6 reserved", 48'hABCD_1234_5678);
    frame(14'd100);
    wrreg(LO, 32'h55, 0);
    wrreg(HI, 32'h7, 0);
    chk48("R8 write without enable", 48'd100);

    for (int d = 0; d <= 40; d++) begin
      wrreg(HI, 32'h0000_FFFF, 1);
      wrreg(LO, 32'hFFFF_FFFF - 32'(d), 1);
      frame(14'd20);
      e = (d < 20) ? MAX : MAX - 48'(d) + 48'd20;
      chk48("R4 saturate", e);
    end
    wrreg(HI, 32'hFFFF, 1);
    wrreg(LO, 32'hFFFF_FFFF, 1);
    frame(14'd5);
    ti = 0;
    step(0, 0, 0, 0, '0, 1, 0, 0, 0, '0, '0, v);
    chk48("R4 stick at max", MAX);

    wrreg(HI, 32'h5, 1);
    wrreg(LO, 32'hFFFF_FFF0, 1);
    rdreg(LO, v); chk("R5 low read value", v, 32'hFFFF_FFF0);
    frame(14'h20);
    rdreg(HI, v); chk("R5 captured high half", v, 32'h5);
    chk48("R5 cleared then added", 48'h20);

    frame(14'd300);
    rdreg(HI, v); chk("R6 high read old capture", v, 32'h0);
    chk48("R6 high read keeps count", 48'd300);

    frame(14'd10);
    step(1, 1, 1, 0, 14'd7, 0, 1, 0, 0, LO, '0, v);
    chk("R7 read returns prior", v, 32'd10);
    chk48("R7 concurrent add kept", 48'd7);

    step(0, 0, 0, 0, '0, 1, 0, 0, 0, '0, '0, v);
    chk48("R9 single increment", 48'd1);
    step(1, 1, 1, 0, 14'd9, 1, 0, 0, 0, '0, '0, v);
    chk48("R9 increment with frame", 48'd10);
    for (int i = 0; i < 5; i++) step(0, 0, 0, 0, '0, 1, 0, 0, 0, '0, '0, v);
    chk48("R9 repeated increment", 48'd5);

    frame(14'd40);
    step(0, 0, 0, 0, '0, 0, 1, 1, 1, LO, 32'd999, v);
    chk("R10 read wins over write", v, 32'd40);
    chk48("R10 write dropped", 48'd0);
    step(1, 1, 1, 0, 14'd5, 0, 0, 1, 1, LO, 32'd77, v);
    chk48("R10 write overrides add", 48'd77);

    frame(14'd12);
    rdreg(9'h158, v); chk("R11 unmapped read zero", v, 32'h0);
    chk48("R11 unmapped read no clear", 48'd12);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule